// File: doc/BRIEF.md
# Partitioned Performance Counter Bank

This block holds six 32-bit event counters whose control and visibility are split by a programmable boundary. Counters with an index below the effective boundary form the guest group: a global guest enable input gates their counting, and lower privilege levels may reach them. Counters at or above the boundary form the hypervisor group: a hypervisor enable bit, held in the block's control register, gates their counting, and in non-secure state only level 2 and above may reach them.

The hypervisor programs the 5-bit boundary and the hypervisor enable through a control write port. It reads back the boundary exactly as written. When the block uses the boundary internally, values above six are clamped to six. Software reaches the counters through a single request port. Each request names a counter index, a privilege level (0 user, 1 kernel, 2 hypervisor, 3 monitor), a security state and a user-access permission. The block answers one cycle later with a grant or a trap. A granted read returns the counter value. A granted write loads the counter.

The access path is a three-state machine. ST_IDLE means no response is pending. ST_GRANT means the previous cycle's request was allowed. ST_TRAP means it was refused. From any state, a valid request moves the machine to ST_GRANT or ST_TRAP according to the permission rules, and a cycle without a request moves it to ST_IDLE.

Top module: `pcb_bank`

## Requirements
- R1: After reset every counter reads 0, the boundary reads back 6, the hypervisor enable reads back 0 and no response is valid.
- R2: A counter that is enabled and sees its event pulse high at a clock edge increments by one, and it wraps from 32'hFFFFFFFF to 0.
- R3: A counter whose index is below min(boundary, 6) counts only while guest_en is 1; the hypervisor enable has no effect on it.
- R4: A counter whose index is at or above min(boundary, 6) counts only while the hypervisor enable bit is 1; guest_en has no effect on it.
- R5: A boundary above 6 places all six counters in the guest group, while ctl_rd_bound still returns the value written.
- R6: A boundary of 0 places every counter in the hypervisor group: non-secure levels 0 and 1 are trapped on every counter, and ctl_rd_bound returns 0.
- R7: In non-secure state a guest-group counter is granted to levels 1, 2 and 3, and to level 0 only when acc_user_ok is 1.
- R8: In non-secure state a hypervisor-group counter is granted only to levels 2 and 3.
- R9: A refused request gives rsp_trap=1 and rsp_rdata=0, and it leaves the addressed counter unchanged even when it is a write.
- R10: rsp_valid is 1 in exactly the cycle after a request. A granted read returns the counter value from the request cycle. A granted write loads acc_wdata at the request edge and takes precedence over a simultaneous event increment.
- R11: A request with an index of 6 or 7 is trapped at every level and in both security states.
- R12: In secure state the boundary does not apply: levels 1 to 3 are granted, and level 0 is granted only when acc_user_ok is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 6 | Per-counter event pulse |
| guest_en | input | 1 | Count enable for the guest group |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_hyp_en | input | 1 | Hypervisor enable value to write |
| ctl_wr_bound | input | 5 | Boundary value to write |
| ctl_rd_bound | output | 5 | Boundary exactly as written |
| ctl_rd_hyp_en | output | 1 | Current hypervisor enable |
| acc_valid | input | 1 | Access request strobe |
| acc_idx | input | 3 | Counter index |
| acc_level | input | 2 | Privilege level, 0 to 3 |
| acc_nonsecure | input | 1 | 1 for a non-secure request |
| acc_user_ok | input | 1 | Level 0 access permission |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_trap | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data, 0 when trapped |
| cnt_value | output | 192 | Counter values, counter i at bits [32*i+31:32*i] |

## Verification
The counter assertions assume that an event pulse and a granted write to the same counter may coincide, and that in this case the write wins. The bench creates that collision on purpose. The response assertions assume that acc_idx is stable only within its request cycle. The bench therefore drives every request for exactly one cycle and returns acc_valid to 0 before it samples. Control writes are never issued in the same cycle as a request, so each grant is judged against a boundary that has already settled.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_TRAP  = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        LVL_USER   = 2'd0,
        LVL_KERNEL = 2'd1,
        LVL_HYP    = 2'd2,
        LVL_MON    = 2'd3
    } priv_lvl_e;

endpackage

// File: rtl/pcb_ctl.sv
module pcb_ctl #(
    parameter int NUM_CNT = 6,
    parameter int BND_W   = 5,
    parameter int BND_RST = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hyp_en,
    input  logic [BND_W-1:0]   wr_bound,
    output logic [BND_W-1:0]   rd_bound,
    output logic               hyp_en,
    output logic [NUM_CNT-1:0] low_mask
);
    localparam logic [BND_W-1:0] CNT_LIM = BND_W'(NUM_CNT);

    logic [BND_W-1:0] bound_q;
    logic             hyp_q;
    logic [BND_W-1:0] eff_bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= BND_W'(BND_RST);
            hyp_q   <= 1'b0;
        end else if (wr_en) begin
            bound_q <= wr_bound;
            hyp_q   <= wr_hyp_en;
        end
    end

    always_comb begin
        eff_bound = (bound_q > CNT_LIM) ? CNT_LIM : bound_q;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_mask
        assign low_mask[i] = (BND_W'(i) < eff_bound);
    end

    assign rd_bound = bound_q;
    assign hyp_en   = hyp_q;

    AST_ZERO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bound == '0) |-> (low_mask == '0)); // R6
    AST_CLAMP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bound >= CNT_LIM) |-> (low_mask == '1)); // R5
    AST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_bound == $past(wr_bound))); // R5

endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             in_low,
    input  logic             guest_en,
    input  logic             hyp_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] value
);
    logic cnt_en;
    logic [CNT_W-1:0] value_q;

    always_comb begin
        cnt_en = in_low ? guest_en : hyp_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_en) begin
            value_q <= wr_data;
        end else if (cnt_en && evt) begin
            value_q <= value_q + CNT_W'(1);
        end
    end

    assign value = value_q;

    AST_INCR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_en && evt) |=> (value == $past(value) + CNT_W'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(cnt_en && evt)) |=> $stable(value)); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data))); // R10

endmodule

// File: rtl/pcb_access.sv
module pcb_access
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 6,
    parameter int CNT_W   = 32,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [IDX_W-1:0]              acc_idx,
    input  logic [1:0]                    acc_level,
    input  logic                          acc_nonsecure,
    input  logic                          acc_user_ok,
    input  logic                          acc_write,
    input  logic [CNT_W-1:0]              acc_wdata,
    input  logic [NUM_CNT-1:0]            low_mask,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    output logic [NUM_CNT-1:0]            wr_vec,
    output logic [CNT_W-1:0]              wr_data,
    output logic                          rsp_valid,
    output logic                          rsp_trap,
    output logic [CNT_W-1:0]              rsp_rdata
);
    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_CNT);

    acc_state_e state_q, state_d;
    logic       idx_ok;
    logic       in_low;
    logic       allow;
    priv_lvl_e  lvl;
    logic [CNT_W-1:0] sel_val;
    logic [CNT_W-1:0] rdata_q;

    always_comb begin
        lvl     = priv_lvl_e'(acc_level);
        idx_ok  = (acc_idx < IDX_LIM);
        in_low  = 1'b0;
        sel_val = '0;
        if (idx_ok) begin
            in_low  = low_mask[acc_idx];
            sel_val = cnt_q[acc_idx];
        end
        allow = 1'b0;
        if (idx_ok) begin
            unique case (lvl)
                LVL_MON:    allow = 1'b1;
                LVL_HYP:    allow = 1'b1;
                LVL_KERNEL: allow = !acc_nonsecure || in_low;
                LVL_USER:   allow = acc_user_ok && (!acc_nonsecure || in_low);
                default:    allow = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_TRAP: begin
                if (acc_valid) begin
                    state_d = allow ? ST_GRANT : ST_TRAP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc_valid) begin
            rdata_q <= allow ? sel_val : '0;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_wr
        assign wr_vec[i] = acc_valid && allow && acc_write && (acc_idx == IDX_W'(i));
    end
    assign wr_data = acc_wdata;

    always_comb begin
        rsp_valid = 1'b0;
        rsp_trap  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_GRANT: rsp_valid = 1'b1;
            ST_TRAP:  begin rsp_valid = 1'b1; rsp_trap = 1'b1; end
            default:  ;
        endcase
        rsp_rdata = rdata_q;
    end

    AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_rdata == '0)); // R9
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R10
    AST_RESP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid); // R10
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_idx >= IDX_LIM)) |=> rsp_trap); // R11
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R10

endmodule

// File: rtl/pcb_bank.sv
module pcb_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 6,
    parameter int CNT_W   = 32,
    parameter int BND_W   = 5,
    parameter int BND_RST = 6,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CNT-1:0]       evt_pulse,
    input  logic                     guest_en,
    input  logic                     ctl_wr_en,
    input  logic                     ctl_wr_hyp_en,
    input  logic [BND_W-1:0]         ctl_wr_bound,
    output logic [BND_W-1:0]         ctl_rd_bound,
    output logic                     ctl_rd_hyp_en,
    input  logic                     acc_valid,
    input  logic [IDX_W-1:0]         acc_idx,
    input  logic [1:0]               acc_level,
    input  logic                     acc_nonsecure,
    input  logic                     acc_user_ok,
    input  logic                     acc_write,
    input  logic [CNT_W-1:0]         acc_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_trap,
    output logic [CNT_W-1:0]         rsp_rdata,
    output logic [NUM_CNT*CNT_W-1:0] cnt_value
);
    logic [NUM_CNT-1:0]            low_mask;
    logic                          hyp_en;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CNT-1:0]            wr_vec;
    logic [CNT_W-1:0]              wr_data;

    pcb_ctl #(
        .NUM_CNT (NUM_CNT),
        .BND_W   (BND_W),
        .BND_RST (BND_RST)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr_en),
        .wr_hyp_en (ctl_wr_hyp_en),
        .wr_bound  (ctl_wr_bound),
        .rd_bound  (ctl_rd_bound),
        .hyp_en    (hyp_en),
        .low_mask  (low_mask)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pcb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_pulse[i]),
            .in_low   (low_mask[i]),
            .guest_en (guest_en),
            .hyp_en   (hyp_en),
            .wr_en    (wr_vec[i]),
            .wr_data  (wr_data),
            .value    (cnt_q[i])
        );
    end

    pcb_access #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .IDX_W   (IDX_W)
    ) u_acc (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_idx       (acc_idx),
        .acc_level     (acc_level),
        .acc_nonsecure (acc_nonsecure),
        .acc_user_ok   (acc_user_ok),
        .acc_write     (acc_write),
        .acc_wdata     (acc_wdata),
        .low_mask      (low_mask),
        .cnt_q         (cnt_q),
        .wr_vec        (wr_vec),
        .wr_data       (wr_data),
        .rsp_valid     (rsp_valid),
        .rsp_trap      (rsp_trap),
        .rsp_rdata     (rsp_rdata)
    );

    assign ctl_rd_hyp_en = hyp_en;
    assign cnt_value     = cnt_q;

    AST_HYP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_nonsecure && (acc_level < 2'd2) && (acc_idx < IDX_W'(NUM_CNT))
         && !low_mask[acc_idx]) |=> rsp_trap); // R8

endmodule

// File: tb/test_pcb_bank.sv
module test_pcb_bank;
    localparam int N = 6;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_pulse = '0;
    logic          guest_en = 1'b0;
    logic          ctl_wr_en = 1'b0;
    logic          ctl_wr_hyp_en = 1'b0;
    logic [4:0]    ctl_wr_bound = '0;
    logic [4:0]    ctl_rd_bound;
    logic          ctl_rd_hyp_en;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_idx = '0;
    logic [1:0]    acc_level = '0;
    logic          acc_nonsecure = 1'b0;
    logic          acc_user_ok = 1'b0;
    logic          acc_write = 1'b0;
    logic [W-1:0]  acc_wdata = '0;
    logic          rsp_valid;
    logic          rsp_trap;
    logic [W-1:0]  rsp_rdata;
    logic [N*W-1:0] cnt_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [W-1:0] model [N];
    int   m_bound = 6;
    bit   m_hyp = 1'b0;

    always #2 clk = ~clk;

    pcb_bank i_pcb_bank (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .guest_en(guest_en),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_hyp_en(ctl_wr_hyp_en), .ctl_wr_bound(ctl_wr_bound),
        .ctl_rd_bound(ctl_rd_bound), .ctl_rd_hyp_en(ctl_rd_hyp_en),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_level(acc_level),
        .acc_nonsecure(acc_nonsecure), .acc_user_ok(acc_user_ok), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap),
        .rsp_rdata(rsp_rdata), .cnt_value(cnt_value)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] cnt(input int i);
        return cnt_value[i*W +: W];
    endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) chk(tag, cnt(i), model[i]);
    endtask

    task automatic set_ctl(input bit hyp, input logic [4:0] bnd);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_hyp_en = hyp; ctl_wr_bound = bnd;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        m_hyp = hyp; m_bound = (bnd > 6) ? 6 : int'(bnd);
    endtask

    task automatic pulse(input logic [N-1:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_pulse = mask;
            for (int i = 0; i < N; i++)
                if (mask[i] && ((i < m_bound) ? guest_en : m_hyp)) model[i] = model[i] + 1;
        end
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic do_req(input string tag, input int idx, input int lvl, input bit ns,
                          input bit usr, input bit wr, input logic [W-1:0] wd, input bit exp_grant);
        logic [W-1:0] exp_rd;
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'(idx); acc_level = 2'(lvl); acc_nonsecure = ns;
        acc_user_ok = usr; acc_write = wr; acc_wdata = wd;
        exp_rd = (exp_grant && idx < N) ? model[idx] : '0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        chk({tag, " valid"}, W'(rsp_valid), W'(1));
        chk({tag, " trap"}, W'(rsp_trap), W'(!exp_grant));
        chk({tag, " rdata"}, rsp_rdata, exp_rd);
        if (exp_grant && wr && idx < N) model[idx] = wd;
        if (idx < N) chk({tag, " counter"}, cnt(idx), model[idx]);
    endtask

    task automatic t_reset;
        chk("R1 bound", W'(ctl_rd_bound), W'(6));
        chk("R1 hyp", W'(ctl_rd_hyp_en), W'(0));
        chk("R1 rsp", W'(rsp_valid), W'(0));
        check_all("R1 counters");
    endtask

    task automatic t_groups;
        guest_en = 1'b1;
        pulse('1, 3);
        check_all("R3 all low");
        set_ctl(1'b0, 5'd2);
        pulse('1, 2);
        check_all("R3 guest only low");
        guest_en = 1'b0;
        set_ctl(1'b1, 5'd2);
        pulse('1, 1);
        check_all("R4 hyp only high");
        pulse(6'b001000, 2);
        check_all("R2 single event");
    endtask

    task automatic t_wrap;
        do_req("R10 write max", 4, 2, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1);
        pulse(6'b010000, 1);
        chk("R2 wrap", cnt(4), 32'h0);
        guest_en = 1'b1;
        @(negedge clk);
        evt_pulse = 6'b000010;
        acc_valid = 1'b1; acc_idx = 3'd1; acc_level = 2'd1; acc_nonsecure = 1'b1;
        acc_write = 1'b1; acc_wdata = 32'h0000_0ABC;
        @(negedge clk);
        evt_pulse = '0; acc_valid = 1'b0; acc_write = 1'b0;
        model[1] = 32'h0000_0ABC;
        chk("R10 write beats event", cnt(1), 32'h0000_0ABC);
        guest_en = 1'b0;
        do_req("R10 read back", 1, 1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_clamp;
        set_ctl(1'b0, 5'd31);
        chk("R5 readback", W'(ctl_rd_bound), W'(31));
        guest_en = 1'b1;
        pulse('1, 1);
        check_all("R5 all guest");
        guest_en = 1'b0;
        do_req("R5 kernel idx5", 5, 1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_zero;
        set_ctl(1'b0, 5'd0);
        chk("R6 readback", W'(ctl_rd_bound), W'(0));
        guest_en = 1'b1;
        pulse('1, 1);
        check_all("R6 guest no effect");
        guest_en = 1'b0;
        set_ctl(1'b1, 5'd0);
        pulse('1, 1);
        check_all("R6 hyp counts all");
        do_req("R6 kernel idx0", 0, 1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        do_req("R6 user idx0", 0, 0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        do_req("R6 hyp idx0", 0, 2, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_nonsecure;
        set_ctl(1'b0, 5'd3);
        do_req("R7 user no perm", 1, 0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        do_req("R7 user perm", 1, 0, 1'b1, 1'b1, 1'b0, '0, 1'b1);
        do_req("R7 kernel low", 2, 1, 1'b1, 1'b0, 1'b0, '0, 1'b1);
        do_req("R8 kernel high", 3, 1, 1'b1, 1'b0, 1'b0, '0, 1'b0);
        do_req("R8 user high", 4, 0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
        do_req("R8 hyp high", 4, 2, 1'b1, 1'b0, 1'b0, '0, 1'b1);
        do_req("R8 monitor high", 5, 3, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_trap_write;
        do_req("R9 denied write", 5, 1, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 1'b0);
        do_req("R9 denied user write", 0, 0, 1'b1, 1'b0, 1'b1, 32'h0000_0055, 1'b0);
    endtask

    task automatic t_bad_idx;
        do_req("R11 idx6 monitor", 6, 3, 1'b0, 1'b1, 1'b0, '0, 1'b0);
        do_req("R11 idx7 hyp", 7, 2, 1'b1, 1'b1, 1'b1, 32'h1, 1'b0);
        check_all("R11 no change");
    endtask

    task automatic t_secure;
        set_ctl(1'b0, 5'd0);
        do_req("R12 kernel", 5, 1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        do_req("R12 user no perm", 2, 0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        do_req("R12 user perm", 2, 0, 1'b0, 1'b1, 1'b0, '0, 1'b1);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_groups();
        t_wrap();
        t_clamp();
        t_zero();
        t_nonsecure();
        t_trap_write();
        t_bad_idx();
        t_secure();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
            $finish;
        end
    end

endmodule